// File: doc/BRIEF.md
# Note-Code Square-Wave Tone Generator

This block converts an 8-bit note number, presented on a parallel input, into a square wave on a single audio output. A note number of zero, or one beyond the top of the note table, gives silence with the output held low. Any other number selects a semitone from a table that is computed at elaboration. The table covers just over eight octaves, and pitch falls as the number rises. Each table entry holds two limits. An inner counter runs up to the inner limit, and each time it wraps it advances an outer counter. A half-period ends when the outer counter reaches the outer limit, so each half lasts inner × outer base ticks. The high and low halves have equal length.

The note input is treated as asynchronous and passes through a two-flop synchronizer. The block acts on a new number in only two situations: while it is silent, or at the close of a full period, which is the end of a low half. A changed number at that point costs one clock for the table lookup. The new note then always begins with its high half. The base tick comes from an enable input that is divided by a parameter. The pitch therefore scales with the tick rate: doubling the tick rate moves every note up one octave.

Top module: `tone_gen`

## Requirements
- R1: The reset is synchronous and active high. It drives the output low and clears both counters. With a zero note number the output stays low after reset.
- R2: While the synchronized note number is 0 the block is silent and the output is held low.
- R3: Note numbers above NUM_CODES (98 by default), for example 99 and 255, are silent. A valid number applied afterwards plays normally.
- R4: The outer limit is 1 for note numbers 1..44, 5 for 45..74 and 25 for 75..98.
- R5: The inner limit is floor((M[s] << o) / outer). Here s = (n-1) mod 12, o = (n-1) div 12, and M = 16,17,18,19,20,21,23,24,25,27,29,30.
- R6: The high half and the low half each last exactly inner × outer base ticks. High comes first.
- R7: After a lookup, the first period of a new note starts with a full-length high half.
- R8: The note number is compared with the playing one only at the end of a low half. If it is unchanged, the next high half starts on the next clock with no gap. If it has changed, exactly one extra low clock is spent on the lookup. A change that is undone within a period has no effect on that period.
- R9: State advances only on base ticks. With tick_en low the output is frozen, and a tick_en asserted every other clock doubles each half in clocks.
- R10: One base tick occurs per TICK_DIV clocks with tick_en high. For example, TICK_DIV=3 triples each half.
- R11: When a nonzero number is applied to a silent block between clock edges, the output goes high after the fourth rising edge: two synchronizer stages, one compare and one lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base-tick enable, divided by TICK_DIV |
| note_code | input | CODE_W (8) | Asynchronous note number; 0 means silence |
| audio_out | output | 1 | Square-wave audio output |

## Verification
Two things can land in the same clock: a new note number reaching the synchronizer output, and the terminal tick that ends a low half. The bench provokes this by changing the input at a sweep of offsets between zero and five clocks before that terminal tick. For each offset it predicts whether the change is caught at this boundary or at the next one, from the two-stage synchronizer delay. It then checks that the low half lasted either exactly its own length or that length plus the one lookup clock. It also checks that the high half which follows has the length of the old note or of the new note, whichever matches that outcome.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } tone_state_e;

    localparam int SEMIS_PER_OCT = 12;

    // Semitone mantissa: roughly 16 * 2^(s/12)
    function automatic int note_mant(input int s);
        case (s)
            0:  return 16;
            1:  return 17;
            2:  return 18;
            3:  return 19;
            4:  return 20;
            5:  return 21;
            6:  return 23;
            7:  return 24;
            8:  return 25;
            9:  return 27;
            10: return 29;
            11: return 30;
            default: return 16;
        endcase
    endfunction

    function automatic int note_outer(input int code, input int mid_first,
                                      input int low_first, input int mid_mult,
                                      input int low_mult);
        if (code >= low_first) return low_mult;
        if (code >= mid_first) return mid_mult;
        return 1;
    endfunction

    function automatic int note_inner(input int code, input int mid_first,
                                      input int low_first, input int mid_mult,
                                      input int low_mult);
        int s;
        int o;
        s = (code - 1) % SEMIS_PER_OCT;
        o = (code - 1) / SEMIS_PER_OCT;
        return (note_mant(s) << o) /
               note_outer(code, mid_first, low_first, mid_mult, low_mult);
    endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/tone_tick.sv
module tone_tick #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            logic unused_pins;
            assign unused_pins = ^{clk, rst};
            assign tick = tick_en;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (tick_en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
            end

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_d;
            end

            assign tick = tick_en && (cnt_q == LAST);

            AST_DIV_WRAP: assert property (@(posedge clk) disable iff (rst)
                (tick_en && cnt_q == LAST) |=> (cnt_q == '0)); // R10
        end
    endgenerate
endmodule

// File: rtl/tone_rom.sv
module tone_rom #(
    parameter int CODE_W    = 8,
    parameter int NUM_CODES = 98,
    parameter int INNER_W   = 8,
    parameter int OUTER_W   = 5,
    parameter int MID_FIRST = 45,
    parameter int LOW_FIRST = 75,
    parameter int MID_MULT  = 5,
    parameter int LOW_MULT  = 25
) (
    input  logic [CODE_W-1:0]  code,
    output logic [INNER_W-1:0] inner_lim,
    output logic [OUTER_W-1:0] outer_lim,
    output logic               valid
);
    localparam int IDX_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;

    logic [INNER_W-1:0] tab_inner [NUM_CODES];
    logic [OUTER_W-1:0] tab_outer [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign tab_inner[g] = INNER_W'(tone_pkg::note_inner(g + 1, MID_FIRST,
                                       LOW_FIRST, MID_MULT, LOW_MULT));
        assign tab_outer[g] = OUTER_W'(tone_pkg::note_outer(g + 1, MID_FIRST,
                                       LOW_FIRST, MID_MULT, LOW_MULT));
    end

    logic [CODE_W-1:0] off;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        valid     = (code != '0) && (32'(code) <= NUM_CODES);
        off       = code - CODE_W'(1);
        idx       = valid ? IDX_W'(off) : '0;
        inner_lim = tab_inner[idx];
        outer_lim = tab_outer[idx];
    end
endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
    parameter int CODE_W    = 8,
    parameter int NUM_CODES = 98,
    parameter int INNER_W   = 8,
    parameter int OUTER_W   = 5,
    parameter int MID_FIRST = 45,
    parameter int LOW_FIRST = 75,
    parameter int MID_MULT  = 5,
    parameter int LOW_MULT  = 25,
    parameter int TICK_DIV  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] note_code,
    output logic              audio_out
);
    import tone_pkg::*;

    localparam logic [INNER_W-1:0] IONE = INNER_W'(1);
    localparam logic [OUTER_W-1:0] OONE = OUTER_W'(1);

    typedef struct packed {
        tone_state_e        st;
        logic [CODE_W-1:0]  code;
        logic [INNER_W-1:0] ilim;
        logic [OUTER_W-1:0] olim;
        logic [INNER_W-1:0] icnt;
        logic [OUTER_W-1:0] ocnt;
        logic               out;
    } tone_regs_t;

    tone_regs_t r_d, r_q;

    logic [CODE_W-1:0]  code_s;
    logic               tick;
    logic [INNER_W-1:0] rom_inner;
    logic [OUTER_W-1:0] rom_outer;
    logic               rom_valid;
    logic               half_done;

    tone_sync #(.W(CODE_W)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (note_code),
        .dout (code_s)
    );

    tone_tick #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .tick    (tick)
    );

    tone_rom #(
        .CODE_W    (CODE_W),
        .NUM_CODES (NUM_CODES),
        .INNER_W   (INNER_W),
        .OUTER_W   (OUTER_W),
        .MID_FIRST (MID_FIRST),
        .LOW_FIRST (LOW_FIRST),
        .MID_MULT  (MID_MULT),
        .LOW_MULT  (LOW_MULT)
    ) u_rom (
        .code      (r_q.code),
        .inner_lim (rom_inner),
        .outer_lim (rom_outer),
        .valid     (rom_valid)
    );

    always_comb begin
        r_d       = r_q;
        half_done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.out = 1'b0;
                if (code_s != r_q.code) begin
                    r_d.st   = ST_LOOK;
                    r_d.code = code_s;
                end
            end
            ST_LOOK: begin
                r_d.icnt = '0;
                r_d.ocnt = '0;
                if (rom_valid) begin
                    r_d.ilim = rom_inner;
                    r_d.olim = rom_outer;
                    r_d.st   = ST_HIGH;
                    r_d.out  = 1'b1;
                end else begin
                    r_d.st  = ST_IDLE;
                    r_d.out = 1'b0;
                end
            end
            default: begin
                if (tick) begin
                    if (r_q.icnt == r_q.ilim - IONE) begin
                        r_d.icnt = '0;
                        if (r_q.ocnt == r_q.olim - OONE) begin
                            r_d.ocnt  = '0;
                            half_done = 1'b1;
                        end else begin
                            r_d.ocnt = r_q.ocnt + OONE;
                        end
                    end else begin
                        r_d.icnt = r_q.icnt + IONE;
                    end
                end
                if (half_done) begin
                    if (r_q.st == ST_HIGH) begin
                        r_d.st  = ST_LOW;
                        r_d.out = 1'b0;
                    end else if (code_s == r_q.code) begin
                        r_d.st  = ST_HIGH;
                        r_d.out = 1'b1;
                    end else begin
                        r_d.st   = ST_LOOK;
                        r_d.code = code_s;
                        r_d.out  = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, code: '0, ilim: '0, olim: '0,
                     icnt: '0, ocnt: '0, out: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign audio_out = r_q.out;

    AST_IDLE_IS_LOW: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE) |-> !audio_out); // R2
    AST_INNER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_HIGH || r_q.st == ST_LOW) |-> (r_q.icnt < r_q.ilim)); // R6
    AST_OUTER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_HIGH || r_q.st == ST_LOW) |-> (r_q.ocnt < r_q.olim)); // R6
    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_LOOK) |=> (audio_out || r_q.st == ST_IDLE)); // R7
    AST_NO_CHANGE_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_HIGH) |=> $stable(r_q.code)); // R8
    AST_LIMITS_HELD: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_HIGH || r_q.st == ST_LOW) |=>
        ($stable(r_q.ilim) && $stable(r_q.olim))); // R4
    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && (r_q.st == ST_HIGH || r_q.st == ST_LOW)) |=> $stable(audio_out)); // R9
endmodule

// File: tb/sim_tone_gen.sv
`timescale 1ns/1ps
module sim_tone_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic [7:0] note = 8'd0;
    logic       out0, out1;
    logic       tick_mode = 1'b0;
    logic       tick_hold = 1'b1;
    int         errs = 0;
    int         checks = 0;

    localparam int MANT [12] = '{16, 17, 18, 19, 20, 21, 23, 24, 25, 27, 29, 30};

    tone_gen u0 (.clk(clk), .rst(rst), .tick_en(tick_en), .note_code(note), .audio_out(out0));
    tone_gen #(.TICK_DIV(3)) u1 (.clk(clk), .rst(rst), .tick_en(1'b1), .note_code(note), .audio_out(out1));

    initial forever #2 clk = ~clk;

    initial forever begin
        @(negedge clk);
        if (tick_mode) tick_en = ~tick_en;
        else           tick_en = tick_hold;
    end

    function automatic int exp_half(int c);
        int s = (c - 1) % 12;
        int o = (c - 1) / 12;
        int outr = (c >= 75) ? 25 : ((c >= 45) ? 5 : 1);
        return ((MANT[s] << o) / outr) * outr;
    endfunction

    task automatic check_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic smp(int sel);
        return (sel != 0) ? out1 : out0;
    endfunction

    task automatic wait_level(int sel, logic lvl);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (smp(sel) == lvl) return;
        end
    endtask

    task automatic wait_rise(int sel);
        wait_level(sel, 1'b0);
        wait_level(sel, 1'b1);
    endtask

    task automatic run_len(int sel, logic lvl, output int n);
        n = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (smp(sel) != lvl) return;
            n++;
        end
    endtask

    task automatic play_measure(int sel, int c, output int h, output int l);
        note = 8'(c);
        wait_rise(sel);
        wait_rise(sel);
        run_len(sel, 1'b1, h);
        run_len(sel, 1'b0, l);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R6 watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int h, l, n, hi_seen;
        logic v;
        // R1: reset holds output low
        repeat (3) @(negedge clk);
        check_int("R1", "out during reset", int'(out0), 0);
        rst = 1'b0;
        hi_seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (out0) hi_seen++;
        end
        check_int("R1", "high samples after reset, code 0", hi_seen, 0);

        // R11: synchronizer plus compare plus lookup latency
        note = 8'd1;
        n = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (out0) begin n = i; break; end
        end
        check_int("R11", "edges until first high", n, 4);
        run_len(0, 1'b1, h);
        check_int("R7", "first high half from silence", h, exp_half(1));

        // R4/R5/R6: full sweep of the single-multiplier range
        for (int c = 1; c <= 44; c++) begin
            play_measure(0, c, h, l);
            check_int("R5", $sformatf("high half code %0d", c), h, exp_half(c));
            check_int("R6", $sformatf("low half code %0d", c), l, exp_half(c));
        end
        // R4: lower ranges, selected codes including range edges
        foreach (MANT[k]) begin end
        for (int k = 0; k < 6; k++) begin
            int c;
            case (k)
                0: c = 45;
                1: c = 60;
                2: c = 74;
                3: c = 75;
                4: c = 90;
                default: c = 98;
            endcase
            play_measure(0, c, h, l);
            check_int("R4", $sformatf("high half code %0d", c), h, exp_half(c));
            check_int("R6", $sformatf("low half code %0d", c), l, exp_half(c));
        end

        // R8: change racing the end of a low half
        play_measure(0, 5, h, l);
        for (int d = 0; d <= 5; d++) begin
            bit taken;
            note = 8'd5;
            wait_rise(0);
            wait_rise(0);
            wait_level(0, 1'b0);
            n = 1;
            while (n < exp_half(5) - d) begin
                @(negedge clk);
                n++;
            end
            note = 8'd10;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (out0) break;
                n++;
            end
            run_len(0, 1'b1, h);
            taken = (d >= 2);
            check_int("R8", $sformatf("low half, change %0d before end", d),
                      n, taken ? exp_half(5) + 1 : exp_half(5));
            check_int("R7", $sformatf("next high, change %0d before end", d),
                      h, taken ? exp_half(10) : exp_half(5));
        end

        // R8: change undone inside a high half has no effect
        note = 8'd5;
        wait_rise(0);
        wait_rise(0);
        wait_rise(0);
        n = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (n == 2) note = 8'd10;
            if (n == 6) note = 8'd5;
            if (!out0) break;
            n++;
        end
        run_len(0, 1'b0, l);
        check_int("R8", "high half with reverted change", n, exp_half(5));
        check_int("R8", "low half with reverted change, no lookup gap", l, exp_half(5));

        // R2: code 0 silences
        note = 8'd0;
        repeat (60) @(negedge clk);
        hi_seen = 0;
        repeat (500) begin @(negedge clk); if (out0) hi_seen++; end
        check_int("R2", "high samples with code 0", hi_seen, 0);

        // R3: out-of-range codes silence; recovery afterwards
        for (int k = 0; k < 2; k++) begin
            note = (k == 0) ? 8'd99 : 8'd255;
            repeat (10) @(negedge clk);
            hi_seen = 0;
            repeat (500) begin @(negedge clk); if (out0) hi_seen++; end
            check_int("R3", $sformatf("high samples with code %0d", note), hi_seen, 0);
        end
        play_measure(0, 3, h, l);
        check_int("R3", "valid code after invalid, high", h, exp_half(3));

        // R9: half tick rate doubles, tick_en low freezes
        tick_mode = 1'b1;
        play_measure(0, 1, h, l);
        check_int("R9", "high half at half tick rate", h, 2 * exp_half(1));
        check_int("R9", "low half at half tick rate", l, 2 * exp_half(1));
        tick_mode = 1'b0;
        tick_hold = 1'b0;
        repeat (3) @(negedge clk);
        v = out0;
        hi_seen = 0;
        repeat (200) begin @(negedge clk); if (out0 != v) hi_seen++; end
        check_int("R9", "output changes with tick_en low", hi_seen, 0);
        tick_hold = 1'b1;

        // R10: divided tick on the second instance
        play_measure(1, 2, h, l);
        check_int("R10", "high half with divide by 3", h, 3 * exp_half(2));
        check_int("R10", "low half with divide by 3", l, 3 * exp_half(2));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule